// File: doc/BRIEF.md
# Postfix Stack Arithmetic Core

This block executes a stream of zero-address instructions against a small internal operand stack. Expressions are evaluated in postfix order. Operand instructions place a signed 16-bit value on the stack. Arithmetic instructions carry no operand field: they take the two topmost entries and replace them with one result. A retrieve instruction removes the top entry and presents it on an output port, tagged with a destination index that the surrounding logic uses to route the value.

One instruction is taken per clock through a valid/ready handshake. Every accepted instruction completes in that same clock. Its effect on the result port and on the three error pulses appears in the following cycle. Three conditions are reported as one-cycle pulses, and each has a defined effect on the stack: a push into a full stack, an instruction that needs more entries than the stack holds, and division by zero.

Top module: `stack_calc`

## Requirements
- R1: `in_ready` is low while `rst` is high and high otherwise. After reset the stack is empty, and `out_valid` and all three error outputs are low.
- R2: With `in_op` = 0 (push), `in_data` goes on top of the stack. With `in_op` = 1 (pop) on a non-empty stack, the top entry is removed. In the next cycle `out_valid` pulses high for one cycle, `out_data` holds that entry and `out_dst` holds that instruction's `in_dst`. Entries come back in last-in, first-out order.
- R3: A push on a stack that already holds 8 entries is discarded. `err_overflow` pulses in the next cycle, and the existing entries are kept unchanged.
- R4: A pop on an empty stack pulses `err_underflow` in the next cycle and produces no `out_valid`.
- R5: An arithmetic instruction (`in_op` 2 to 5) issued with fewer than two entries on the stack pulses `err_underflow` and leaves the stack unchanged.
- R6: `in_op` = 2 (subtract) replaces the two top entries with the earlier-pushed entry minus the later-pushed entry.
- R7: `in_op` = 3 (add) replaces the two top entries with their sum. `in_op` = 4 (multiply) replaces them with the low 16 bits of their product. Both results wrap modulo 2^16.
- R8: `in_op` = 5 (divide) replaces the two top entries with the signed quotient of the earlier-pushed entry over the later-pushed entry, truncated toward zero.
- R9: A divide whose later-pushed entry is zero pulses `err_divzero`, removes both operands and pushes 0.
- R10: The sequence push A, push B, subtract, push C, push D, push E, multiply, add, divide, pop Y delivers (A-B)/(C+D*E) tagged Y and leaves the stack empty.
- R11: Instructions may arrive in consecutive cycles with no bubble. Each error output is a one-cycle pulse, and at most one of the three is high in any cycle.
- R12: `in_op` values 6 and 7 are ignored. They change no stack entry, raise no error and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Core accepts an instruction this cycle |
| in_op | input | 3 | Opcode: 0 push, 1 pop, 2 sub, 3 add, 4 mul, 5 div |
| in_data | input | 16 | Push operand |
| in_dst | input | 4 | Destination tag for pop |
| out_valid | output | 1 | Popped value present (one cycle) |
| out_data | output | 16 | Popped value |
| out_dst | output | 4 | Destination tag of popped value |
| err_overflow | output | 1 | Push into full stack (pulse) |
| err_underflow | output | 1 | Too few entries for the instruction (pulse) |
| err_divzero | output | 1 | Divide by zero (pulse) |

## Verification
Every result of this core is registered once: the instruction accepted at clock edge k shows its popped value, tag and error pulses just after edge k, and they are gone after edge k+1 unless the next instruction produces them again. The bench drives each instruction on a falling edge and samples the outputs 1 ns after the following rising edge. Each check therefore lands in exactly the cycle that belongs to the instruction just issued. Stack contents are never read directly. They are confirmed by popping, so the effects of discarded, ignored and failed instructions are observed through the result port.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int DATA_W = 16;
    localparam int DEPTH  = 8;
    localparam int DST_W  = 4;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_SUB  = 3'd2,
        OP_ADD  = 3'd3,
        OP_MUL  = 3'd4,
        OP_DIV  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SC_HOLD,
        SC_PUSH,
        SC_POP,
        SC_FOLD
    } stk_cmd_e;

    typedef struct packed {
        logic ovf;
        logic udf;
        logic dz;
    } err_t;

    function automatic logic is_arith(op_e op);
        return (op == OP_SUB) || (op == OP_ADD) || (op == OP_MUL) || (op == OP_DIV);
    endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_e          op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] result,
    output logic         div_zero
);
    logic signed [W:0] lhs_x;
    logic signed [W:0] rhs_x;
    logic signed [W:0] quo_x;

    always_comb begin
        lhs_x    = {lhs[W-1], lhs};
        rhs_x    = (rhs == '0) ? (W+1)'(1) : {rhs[W-1], rhs};
        quo_x    = lhs_x / rhs_x;
        div_zero = (op == OP_DIV) && (rhs == '0);
        unique case (op)
            OP_SUB:  result = lhs - rhs;
            OP_ADD:  result = lhs + rhs;
            OP_MUL:  result = lhs * rhs;
            OP_DIV:  result = div_zero ? '0 : quo_x[W-1:0];
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/stk_file.sv
module stk_file
    import stk_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int DEPTH_P = DEPTH,
    localparam int IW   = $clog2(DEPTH_P),
    localparam int CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_cmd_e      cmd,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  top,
    output logic [W-1:0]  second,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH_P);

    logic [W-1:0]  mem [DEPTH_P];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_m1;
    logic [CW-1:0] cnt_m2;

    assign cnt_m1 = cnt_q - CW'(1);
    assign cnt_m2 = cnt_q - CW'(2);
    assign top    = (cnt_q >= CW'(1)) ? mem[cnt_m1[IW-1:0]] : '0;
    assign second = (cnt_q >= CW'(2)) ? mem[cnt_m2[IW-1:0]] : '0;
    assign count  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (cmd)
                SC_PUSH: begin
                    mem[cnt_q[IW-1:0]] <= wdata;
                    cnt_q <= cnt_q + CW'(1);
                end
                SC_POP:  cnt_q <= cnt_m1;
                SC_FOLD: begin
                    mem[cnt_m2[IW-1:0]] <= wdata;
                    cnt_q <= cnt_m1;
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL) else $error("stack count beyond depth"); // R3

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_PUSH) |=> (cnt_q == $past(cnt_q) + CW'(1))) else $error("push did not grow"); // R2

    AST_FOLD_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_FOLD) |=> (top == $past(wdata))) else $error("fold result not on top"); // R6

endmodule

// File: rtl/stack_calc.sv
module stack_calc
    import stk_pkg::*;
#(
    parameter int W       = DATA_W,
    parameter int DEPTH_P = DEPTH,
    parameter int DW      = DST_W,
    localparam int CW     = $clog2(DEPTH_P) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [2:0]    in_op,
    input  logic [W-1:0]  in_data,
    input  logic [DW-1:0] in_dst,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic [DW-1:0] out_dst,
    output logic          err_overflow,
    output logic          err_underflow,
    output logic          err_divzero
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH_P);
    localparam logic [CW-1:0] TWO  = CW'(2);

    op_e           op;
    logic          accept;
    stk_cmd_e      cmd;
    logic [W-1:0]  wdata;
    logic [W-1:0]  top;
    logic [W-1:0]  second;
    logic [CW-1:0] cnt;
    logic [W-1:0]  alu_res;
    logic          alu_dz;
    err_t          err_c;
    err_t          err_q;
    logic          pop_c;
    logic          out_valid_q;
    logic [W-1:0]  out_data_q;
    logic [DW-1:0] out_dst_q;

    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;
    assign op       = op_e'(in_op);

    stk_alu #(.W(W)) u_alu (
        .op       (op),
        .lhs      (second),
        .rhs      (top),
        .result   (alu_res),
        .div_zero (alu_dz)
    );

    stk_file #(.W(W), .DEPTH_P(DEPTH_P)) u_file (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .wdata  (wdata),
        .top    (top),
        .second (second),
        .count  (cnt)
    );

    always_comb begin
        cmd   = SC_HOLD;
        wdata = in_data;
        err_c = '0;
        pop_c = 1'b0;
        if (accept) begin
            if (op == OP_PUSH) begin
                if (cnt == FULL) err_c.ovf = 1'b1;
                else             cmd = SC_PUSH;
            end else if (op == OP_POP) begin
                if (cnt == '0) begin
                    err_c.udf = 1'b1;
                end else begin
                    cmd   = SC_POP;
                    pop_c = 1'b1;
                end
            end else if (is_arith(op)) begin
                if (cnt < TWO) begin
                    err_c.udf = 1'b1;
                end else begin
                    cmd      = SC_FOLD;
                    wdata    = alu_res;
                    err_c.dz = alu_dz;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q       <= '0;
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
            out_dst_q   <= '0;
        end else begin
            err_q       <= err_c;
            out_valid_q <= pop_c;
            if (pop_c) begin
                out_data_q <= top;
                out_dst_q  <= in_dst;
            end
        end
    end

    assign out_valid     = out_valid_q;
    assign out_data      = out_data_q;
    assign out_dst       = out_dst_q;
    assign err_overflow  = err_q.ovf;
    assign err_underflow = err_q.udf;
    assign err_divzero   = err_q.dz;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (accept && in_op == 3'd0 && cnt == FULL) |=> (err_overflow && $stable(cnt)))
        else $error("full push not rejected"); // R3

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (accept && in_op == 3'd1 && cnt == '0) |=> (err_underflow && !out_valid))
        else $error("empty pop not flagged"); // R4

    AST_ARITH_SHORT: assert property (@(posedge clk) disable iff (rst)
        (accept && in_op >= 3'd2 && in_op <= 3'd5 && cnt < TWO) |=> (err_underflow && $stable(cnt)))
        else $error("short arithmetic not flagged"); // R5

    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (accept && in_op == 3'd5 && cnt >= TWO && top == '0) |=> (err_divzero && top == '0))
        else $error("divide by zero mishandled"); // R9

    AST_POP_SOURCE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(accept && in_op == 3'd1))
        else $error("output without pop"); // R2

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_overflow, err_underflow, err_divzero}))
        else $error("several errors at once"); // R11

    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (accept && in_op >= 3'd6) |=> ($stable(cnt) && !out_valid && !err_underflow && !err_overflow))
        else $error("reserved opcode had effect"); // R12

endmodule

// File: tb/stack_calc_tb.sv
module stack_calc_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic [15:0] in_data = '0;
    logic [3:0]  in_dst = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic [3:0]  out_dst;
    logic        err_overflow;
    logic        err_underflow;
    logic        err_divzero;

    int checks = 0;
    int errors = 0;

    logic        s_v, s_ov, s_un, s_dz;
    logic [15:0] s_d;
    logic [3:0]  s_dst;

    localparam logic [2:0] PUSH = 3'd0, POP = 3'd1, SUB = 3'd2,
                           ADD = 3'd3, MUL = 3'd4, DIV = 3'd5;

    always #4 clk = ~clk;

    stack_calc u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
        .in_op (in_op), .in_data (in_data), .in_dst (in_dst),
        .out_valid (out_valid), .out_data (out_data), .out_dst (out_dst),
        .err_overflow (err_overflow), .err_underflow (err_underflow),
        .err_divzero (err_divzero)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic capture();
        s_v = out_valid; s_d = out_data; s_dst = out_dst;
        s_ov = err_overflow; s_un = err_underflow; s_dz = err_divzero;
    endtask

    task automatic issue(input logic [2:0] op, input logic [15:0] d, input logic [3:0] dst);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_data = d; in_dst = dst;
        @(posedge clk); #1;
        capture();
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        capture();
    endtask

    task automatic expect_pop(input string req, input logic [15:0] exp, input logic [3:0] dst);
        issue(POP, 16'h0, dst);
        chk({req, " out_valid"}, 32'(s_v), 32'd1);
        chk({req, " out_data"}, 32'(s_d), 32'(exp));
        chk({req, " out_dst"}, 32'(s_dst), 32'(dst));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 ready in reset", 32'(in_ready), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 ready after reset", 32'(in_ready), 32'd1);
        chk("R1 outputs idle", {28'd0, out_valid, err_overflow, err_underflow, err_divzero}, 32'd0);
    endtask

    task automatic t_reset_empty();
        do_reset();
        issue(POP, 16'h0, 4'd0);
        chk("R1 empty after reset", 32'(s_un), 32'd1);
        chk("R4 no output on empty pop", 32'(s_v), 32'd0);
        idle();
    endtask

    task automatic t_lifo();
        do_reset();
        issue(PUSH, 16'h1111, 4'd0);
        issue(PUSH, 16'h2222, 4'd0);
        issue(PUSH, 16'h3333, 4'd0);
        expect_pop("R2 lifo 1st", 16'h3333, 4'd5);
        expect_pop("R11 back-to-back 2nd", 16'h2222, 4'd12);
        expect_pop("R2 lifo 3rd", 16'h1111, 4'd1);
        idle();
        chk("R2 out_valid one cycle", 32'(s_v), 32'd0);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 1; i <= 8; i++) begin
            issue(PUSH, 16'(i), 4'd0);
            chk("R3 no flag below full", 32'(s_ov), 32'd0);
        end
        issue(PUSH, 16'd99, 4'd0);
        chk("R3 overflow flag", 32'(s_ov), 32'd1);
        idle();
        chk("R11 overflow pulse ends", 32'(s_ov), 32'd0);
        for (int i = 8; i >= 1; i--) expect_pop("R3 entries kept", 16'(i), 4'd3);
        idle();
    endtask

    task automatic t_arith_short();
        do_reset();
        issue(ADD, 16'h0, 4'd0);
        chk("R5 arith on empty", 32'(s_un), 32'd1);
        issue(PUSH, 16'd11, 4'd0);
        issue(MUL, 16'h0, 4'd0);
        chk("R5 arith on one entry", 32'(s_un), 32'd1);
        expect_pop("R5 stack unchanged", 16'd11, 4'd2);
        issue(POP, 16'h0, 4'd0);
        chk("R4 pop now empty", 32'(s_un), 32'd1);
        idle();
    endtask

    task automatic t_sub();
        do_reset();
        issue(PUSH, 16'd50, 4'd0);
        issue(PUSH, 16'd8, 4'd0);
        issue(SUB, 16'h0, 4'd0);
        chk("R6 sub no error", {29'd0, s_ov, s_un, s_dz}, 32'd0);
        expect_pop("R6 sub order", 16'd42, 4'd1);
        issue(PUSH, 16'd3, 4'd0);
        issue(PUSH, 16'd10, 4'd0);
        issue(SUB, 16'h0, 4'd0);
        expect_pop("R6 sub negative", 16'hFFF9, 4'd1);
        idle();
    endtask

    task automatic t_add_mul();
        do_reset();
        issue(PUSH, 16'hFFFF, 4'd0);
        issue(PUSH, 16'd5, 4'd0);
        issue(ADD, 16'h0, 4'd0);
        expect_pop("R7 add signed", 16'd4, 4'd0);
        issue(PUSH, 16'd300, 4'd0);
        issue(PUSH, 16'd300, 4'd0);
        issue(MUL, 16'h0, 4'd0);
        expect_pop("R7 mul low bits", 16'd24464, 4'd0);
        issue(PUSH, 16'hFFFD, 4'd0);
        issue(PUSH, 16'd7, 4'd0);
        issue(MUL, 16'h0, 4'd0);
        expect_pop("R7 mul negative", 16'hFFEB, 4'd0);
        idle();
    endtask

    task automatic t_div();
        do_reset();
        issue(PUSH, 16'hFFF9, 4'd0);
        issue(PUSH, 16'd2, 4'd0);
        issue(DIV, 16'h0, 4'd0);
        chk("R8 no divzero", 32'(s_dz), 32'd0);
        expect_pop("R8 neg over pos", 16'hFFFD, 4'd0);
        issue(PUSH, 16'd7, 4'd0);
        issue(PUSH, 16'hFFFE, 4'd0);
        issue(DIV, 16'h0, 4'd0);
        expect_pop("R8 pos over neg", 16'hFFFD, 4'd0);
        issue(PUSH, 16'd100, 4'd0);
        issue(PUSH, 16'd7, 4'd0);
        issue(DIV, 16'h0, 4'd0);
        expect_pop("R8 positive", 16'd14, 4'd0);
        idle();
    endtask

    task automatic t_divzero();
        do_reset();
        issue(PUSH, 16'd77, 4'd0);
        issue(PUSH, 16'd5, 4'd0);
        issue(PUSH, 16'd0, 4'd0);
        issue(DIV, 16'h0, 4'd0);
        chk("R9 divzero flag", 32'(s_dz), 32'd1);
        idle();
        chk("R11 divzero pulse ends", 32'(s_dz), 32'd0);
        expect_pop("R9 zero pushed", 16'd0, 4'd0);
        expect_pop("R9 operands removed", 16'd77, 4'd0);
        idle();
    endtask

    task automatic t_expression();
        do_reset();
        issue(PUSH, 16'd100, 4'd0);
        issue(PUSH, 16'd9, 4'd0);
        issue(SUB, 16'h0, 4'd0);
        issue(PUSH, 16'd3, 4'd0);
        issue(PUSH, 16'd2, 4'd0);
        issue(PUSH, 16'd5, 4'd0);
        issue(MUL, 16'h0, 4'd0);
        issue(ADD, 16'h0, 4'd0);
        issue(DIV, 16'h0, 4'd0);
        expect_pop("R10 expression", 16'd7, 4'd9);
        issue(POP, 16'h0, 4'd0);
        chk("R10 stack empty", 32'(s_un), 32'd1);
        idle();
    endtask

    task automatic t_reserved();
        do_reset();
        issue(PUSH, 16'd5, 4'd0);
        issue(PUSH, 16'd6, 4'd0);
        issue(3'd6, 16'hAAAA, 4'd1);
        chk("R12 op6 no effect", {28'd0, s_v, s_ov, s_un, s_dz}, 32'd0);
        issue(3'd7, 16'hBBBB, 4'd1);
        chk("R12 op7 no effect", {28'd0, s_v, s_ov, s_un, s_dz}, 32'd0);
        expect_pop("R12 top intact", 16'd6, 4'd4);
        expect_pop("R12 next intact", 16'd5, 4'd4);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_empty();
        t_lifo();
        t_overflow();
        t_arith_short();
        t_sub();
        t_add_mul();
        t_div();
        t_divzero();
        t_expression();
        t_reserved();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule